// File: doc/BRIEF.md
# LCD scan timing generator

This block sequences the row scan of a multiplexed dot-matrix panel. It counts scanned rows per frame according to a 2-bit duty selection (33, 49, 55 or 65 rows). It produces a line clock and a frame alternation level that flips once per frame. For every row it reports the display-memory line to fetch and the common electrode that drives it. The memory line is the row index offset by a start-line register, which lets software scroll the picture. Scrolling only takes effect between frames.

In master mode with the internal divider selected, the line clock is derived from the block clock. The division ratio depends on the duty. With the divider off, or in slave mode, the line clock comes from an external pin and its rising edges advance the scan. In slave mode the alternation level and the display-off level also come from another device. All three external inputs pass through a synchronizer before use. The common electrode is reported as a number: 0 to 63 for the matrix pins, or 64 for the indicator electrode on the last row of each frame.

Top module: `lcd_scan_timer`

## Requirements
- R1: `duty_sel` selects the rows per frame: 2'b00 = 33, 2'b01 = 49, 2'b10 = 55, 2'b11 = 65. `line_idx` counts 0 up to rows-1 and then returns to 0.
- R2: When `master`=1 and `osc_en`=1, one line lasts 12 clocks at 33 rows, 8 clocks at 49 or 55 rows and 6 clocks at 65 rows. `cl_out` is high for the first half of each line period, and `line_idx` advances on the same clock edge where `cl_out` rises.
- R3: In master mode, `fr_out` starts at 0 after reset and inverts exactly on the edge where `line_idx` wraps to 0. It therefore completes one period every two frames.
- R4: `ram_line` equals (active start line + `line_idx`) mod 65.
- R5: `start_line` is captured into the active start line only on the wrap edge of `line_idx`. A change in the middle of a frame has no effect until the next frame. The active start line is 0 after reset.
- R6: With `com_rev`=0, take h = (rows-1)/2. Row r < h drives pin r. Row r with h ≤ r < rows-1 drives pin r + 64 - 2h. Row rows-1 reports 64, the indicator electrode.
- R7: With `com_rev`=1, the matrix rows drive pin 63 minus the pin number from R6, so row 0 drives pin 63. The last row still reports 64.
- R8: When `master`=0 or `osc_en`=0, `cl_out` is `ext_cl` delayed by SYNC_STAGES clocks. `line_idx` advances one clock after the synchronized rising edge. With `master`=1 and `osc_en`=1, `ext_cl` has no effect.
- R9: With `master`=0, `fr_out` and `doff_out` follow `ext_fr` and `ext_doff` through the synchronizer. With `master`=1, `doff_out` equals `disp_off`.
- R10: While `rst_n`=0 on a clock edge, the block returns to row 0 with `fr_out`=0. In master mode with the internal divider, `cl_out`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (oscillator clock in master mode) |
| rst_n | input | 1 | Synchronous active-low reset |
| master | input | 1 | 1 = generate timing, 0 = take timing from another device |
| osc_en | input | 1 | 1 = derive the line clock internally (master only) |
| duty_sel | input | 2 | Rows-per-frame select |
| start_line | input | 6 | Requested scroll start line |
| com_rev | input | 1 | 1 = reversed common scan order |
| disp_off | input | 1 | Display-off level issued in master mode |
| ext_cl | input | 1 | External line clock |
| ext_fr | input | 1 | External alternation level (slave) |
| ext_doff | input | 1 | External display-off level (slave) |
| cl_out | output | 1 | Line clock in use |
| fr_out | output | 1 | Frame alternation level |
| doff_out | output | 1 | Display-off level in use |
| line_idx | output | 7 | Scanned row within the frame |
| ram_line | output | 7 | Display-memory line for this row |
| com_num | output | 7 | Driven common electrode, 64 = indicator |

## Verification
The hardest condition to reach from the ports is a start-line write that lands in the middle of a frame. The write must not show until the wrap, and the offset must also be seen folding past line 64. Every sweep run therefore resets with the start line at 0, loads a first value that is latched at the end of frame one, and writes a second value partway through frame two. The run then follows the scan cycle by cycle into frame three. Start values of 63 and 40 push the sum well past 64. A second hard case is slave mode, where the internal alternation keeps flipping while the output must track the pin. The bench pulses the external clock across a full frame wrap with the external level held at 1.

// File: rtl/lcd_scan_pkg.sv
// Shared constants and helpers for the LCD scan timing generator.
// Assumes the panel has at most 65 scanned rows (64 matrix commons plus one
// indicator common).
package lcd_scan_pkg;

    localparam int LINES_FULL = 65;               // rows in the full display area
    localparam int COM_PINS   = 64;               // matrix common pins
    localparam int LINE_W     = $clog2(LINES_FULL + 1);

    typedef enum logic [1:0] {
        DUTY_33 = 2'b00,
        DUTY_49 = 2'b01,
        DUTY_55 = 2'b10,
        DUTY_65 = 2'b11
    } duty_e;

    // Rows scanned per frame for a duty code.
    function automatic logic [LINE_W-1:0] rows_of(input logic [1:0] code);
        case (duty_e'(code))
            DUTY_33: rows_of = LINE_W'(33);
            DUTY_49: rows_of = LINE_W'(49);
            DUTY_55: rows_of = LINE_W'(55);
            default: rows_of = LINE_W'(65);
        endcase
    endfunction

endpackage

// File: rtl/lcd_in_sync.sv
// Multi-stage synchronizer for external timing inputs.
// Assumes the inputs are levels that stay put for longer than STAGES clocks.
module lcd_in_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the sampled inputs down the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/lcd_line_clk.sv
// Line clock source. In internal mode it divides the block clock by a
// duty-dependent ratio. In external mode it detects rising edges of the
// synchronized external line clock. It emits one line_tick per line.
// Assumes div >= 2 and that div changes only while the block is in reset.
module lcd_line_clk #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_int,
    input  logic [DIV_W-1:0] div,
    input  logic             cl_ext_s,
    output logic             line_tick,
    output logic             cl_out
);

    logic [DIV_W-1:0] dcnt_q;
    logic             prev_q;
    logic             at_end;

    assign at_end = (dcnt_q >= div - DIV_W'(1));

    // Divider counter: runs only while the internal source is selected.
    always_ff @(posedge clk) begin
        if (!rst_n || !use_int) begin
            dcnt_q <= '0;
        end else if (at_end) begin
            dcnt_q <= '0;
        end else begin
            dcnt_q <= dcnt_q + DIV_W'(1);
        end
    end

    // Previous synchronized external level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= cl_ext_s;
        end
    end

    // Select tick and visible line clock for the active source.
    always_comb begin
        if (use_int) begin
            line_tick = at_end;
            cl_out    = (dcnt_q < (div >> 1));
        end else begin
            line_tick = cl_ext_s & ~prev_q;
            cl_out    = cl_ext_s;
        end
    end

endmodule

// File: rtl/lcd_frame_ctr.sv
// Row counter with frame alternation and a start-line register that loads
// only at the frame boundary. Assumes rows >= 2.
module lcd_frame_ctr #(
    parameter int LINE_W  = 7,
    parameter int START_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [LINE_W-1:0]  rows,
    input  logic [START_W-1:0] start_in,
    output logic [LINE_W-1:0]  row_q,
    output logic               fr_q,
    output logic [START_W-1:0] start_q
);

    logic wrap;

    assign wrap = (row_q >= rows - LINE_W'(1));

    // Advance the row per line; on wrap flip alternation and take the new start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            fr_q    <= 1'b0;
            start_q <= '0;
        end else if (tick) begin
            if (wrap) begin
                row_q   <= '0;
                fr_q    <= ~fr_q;
                start_q <= start_in;
            end else begin
                row_q   <= row_q + LINE_W'(1);
            end
        end
    end

endmodule

// File: rtl/lcd_com_map.sv
// Maps the scanned row to a display-memory line (start offset, modulo LINES)
// and to a common electrode number. Reduced duties split the rows across the
// two ends of the pin range. The last row reports the indicator code COM_PINS.
// Assumes rows <= LINES and rows - 1 <= COM_PINS.
module lcd_com_map #(
    parameter int LINE_W   = 7,
    parameter int START_W  = 6,
    parameter int LINES    = 65,
    parameter int COM_PINS = 64
) (
    input  logic [LINE_W-1:0]  row,
    input  logic [LINE_W-1:0]  rows,
    input  logic [START_W-1:0] start,
    input  logic               rev,
    output logic [LINE_W-1:0]  ram_line,
    output logic [LINE_W-1:0]  com_num
);

    localparam int SUM_W = LINE_W + 1;

    logic [SUM_W-1:0]  sum;
    logic [LINE_W-1:0] half;
    logic [LINE_W-1:0] gap;
    logic [LINE_W-1:0] pin;

    // Offset the row by the start line and fold into the display area.
    always_comb begin
        sum = SUM_W'(start) + SUM_W'(row);
        if (sum >= SUM_W'(LINES)) begin
            ram_line = LINE_W'(sum - SUM_W'(LINES));
        end else begin
            ram_line = LINE_W'(sum);
        end
    end

    // Place the row on a pin, mirror it when reversed, flag the indicator row.
    always_comb begin
        half = (rows - LINE_W'(1)) >> 1;
        gap  = LINE_W'(COM_PINS) - (half << 1);
        pin  = (row < half) ? row : row + gap;
        if (row == rows - LINE_W'(1)) begin
            com_num = LINE_W'(COM_PINS);
        end else if (rev) begin
            com_num = LINE_W'(COM_PINS - 1) - pin;
        end else begin
            com_num = pin;
        end
    end

endmodule

// File: rtl/lcd_scan_timer.sv
// Top of the LCD scan timing generator. Chooses the line-clock source
// (internal divider in master mode with osc_en, external pin otherwise),
// counts rows per frame by duty, and maps rows to memory lines and commons.
// Assumes duty_sel, master and osc_en change only while rst_n is low.
module lcd_scan_timer
    import lcd_scan_pkg::*;
#(
    parameter int DIV_FULL    = 6,
    parameter int DIV_MID     = 8,
    parameter int DIV_LOW     = 12,
    parameter int SYNC_STAGES = 2,
    parameter int START_W     = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               master,
    input  logic               osc_en,
    input  logic [1:0]         duty_sel,
    input  logic [START_W-1:0] start_line,
    input  logic               com_rev,
    input  logic               disp_off,
    input  logic               ext_cl,
    input  logic               ext_fr,
    input  logic               ext_doff,
    output logic               cl_out,
    output logic               fr_out,
    output logic               doff_out,
    output logic [LINE_W-1:0]  line_idx,
    output logic [LINE_W-1:0]  ram_line,
    output logic [LINE_W-1:0]  com_num
);

    localparam int DIV_A   = (DIV_LOW > DIV_MID) ? DIV_LOW : DIV_MID;
    localparam int DIV_MAX = (DIV_A > DIV_FULL) ? DIV_A : DIV_FULL;
    localparam int DIV_W   = $clog2(DIV_MAX + 1);

    logic [DIV_W-1:0]   div_now;
    logic [LINE_W-1:0]  rows_now;
    logic               use_int;
    logic [2:0]         sync_bus;
    logic               line_tick;
    logic               fr_int;
    logic [START_W-1:0] start_act;

    assign use_int  = master & osc_en;
    assign rows_now = rows_of(duty_sel);

    // Divider ratio for the selected duty.
    always_comb begin
        case (duty_e'(duty_sel))
            DUTY_33: div_now = DIV_W'(DIV_LOW);
            DUTY_65: div_now = DIV_W'(DIV_FULL);
            default: div_now = DIV_W'(DIV_MID);
        endcase
    end

    lcd_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ext_cl, ext_fr, ext_doff}),
        .dout (sync_bus)
    );

    lcd_line_clk #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .use_int  (use_int),
        .div      (div_now),
        .cl_ext_s (sync_bus[2]),
        .line_tick(line_tick),
        .cl_out   (cl_out)
    );

    lcd_frame_ctr #(.LINE_W(LINE_W), .START_W(START_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (line_tick),
        .rows    (rows_now),
        .start_in(start_line),
        .row_q   (line_idx),
        .fr_q    (fr_int),
        .start_q (start_act)
    );

    lcd_com_map #(
        .LINE_W  (LINE_W),
        .START_W (START_W),
        .LINES   (LINES_FULL),
        .COM_PINS(COM_PINS)
    ) u_map (
        .row     (line_idx),
        .rows    (rows_now),
        .start   (start_act),
        .rev     (com_rev),
        .ram_line(ram_line),
        .com_num (com_num)
    );

    // Alternation and display-off come from this block or the other device.
    always_comb begin
        if (master) begin
            fr_out   = fr_int;
            doff_out = disp_off;
        end else begin
            fr_out   = sync_bus[1];
            doff_out = sync_bus[0];
        end
    end

endmodule

// File: rtl/lcd_scan_chk.sv
// Property checker for lcd_scan_timer, attached by bind below.
module lcd_scan_chk
    import lcd_scan_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              master,
    input logic              osc_en,
    input logic [1:0]        duty_sel,
    input logic              com_rev,
    input logic              cl_out,
    input logic              fr_out,
    input logic [LINE_W-1:0] line_idx,
    input logic [LINE_W-1:0] ram_line,
    input logic [LINE_W-1:0] com_num
);

    a_r1_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        line_idx < rows_of(duty_sel));

    a_r2_cl_rise_moves_line: assert property (@(posedge clk) disable iff (!rst_n)
        (master && osc_en && $rose(cl_out)) |-> (line_idx != $past(line_idx)));

    a_r3_fr_flips_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !$stable(fr_out)) |-> (line_idx == '0));

    a_r4_ram_line_range: assert property (@(posedge clk) disable iff (!rst_n)
        ram_line < LINE_W'(LINES_FULL));

    a_r5_no_midframe_scroll: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(line_idx) && line_idx != '0) |->
        (ram_line == (($past(ram_line) == LINE_W'(LINES_FULL - 1)) ?
                      LINE_W'(0) : $past(ram_line) + LINE_W'(1))));

    a_r6_normal_top_com0: assert property (@(posedge clk) disable iff (!rst_n)
        (!com_rev && line_idx == '0) |-> (com_num == '0));

    a_r7_reversed_top_com63: assert property (@(posedge clk) disable iff (!rst_n)
        (com_rev && line_idx == '0) |-> (com_num == LINE_W'(COM_PINS - 1)));

endmodule

bind lcd_scan_timer lcd_scan_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .master  (master),
    .osc_en  (osc_en),
    .duty_sel(duty_sel),
    .com_rev (com_rev),
    .cl_out  (cl_out),
    .fr_out  (fr_out),
    .line_idx(line_idx),
    .ram_line(ram_line),
    .com_num (com_num)
);

// File: tb/sim_lcd_scan_timer.sv
module sim_lcd_scan_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master = 1'b1, osc_en = 1'b1, com_rev = 1'b0, disp_off = 1'b0;
    logic [1:0] duty_sel = 2'b00;
    logic [5:0] start_line = '0;
    logic       ext_cl = 1'b0, ext_fr = 1'b0, ext_doff = 1'b0;
    logic       cl_out, fr_out, doff_out;
    logic [6:0] line_idx, ram_line, com_num;

    int n_cmp = 0;
    int n_bad = 0;

    always #5ns clk = ~clk;

    lcd_scan_timer u0 (
        .clk(clk), .rst_n(rst_n), .master(master), .osc_en(osc_en),
        .duty_sel(duty_sel), .start_line(start_line), .com_rev(com_rev),
        .disp_off(disp_off), .ext_cl(ext_cl), .ext_fr(ext_fr), .ext_doff(ext_doff),
        .cl_out(cl_out), .fr_out(fr_out), .doff_out(doff_out),
        .line_idx(line_idx), .ram_line(ram_line), .com_num(com_num)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int rows_n(input int d);
        return (d == 0) ? 33 : (d == 1) ? 49 : (d == 2) ? 55 : 65;
    endfunction

    function automatic int div_n(input int d);
        return (d == 0) ? 12 : (d == 3) ? 6 : 8;
    endfunction

    // Expected common number from R6 / R7.
    function automatic int exp_com(input int r, input int n, input bit rev);
        int h, pin;
        if (r == n - 1) return 64;
        h   = (n - 1) / 2;
        pin = (r < h) ? r : r + 64 - 2 * h;
        return rev ? 63 - pin : pin;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Master, internal divider: follow the scan cycle by cycle.
    task automatic run_master(input int d, input int s0, input int s1, input bit rev);
        int n, dv, md, mr, mf, ms, total;
        n  = rows_n(d);
        dv = div_n(d);
        master = 1'b1; osc_en = 1'b1; duty_sel = 2'(d);
        com_rev = rev; start_line = 6'(s0); ext_cl = 1'b0;
        do_reset();
        check("R10 reset line_idx", line_idx, 0);
        check("R10 reset fr_out", fr_out, 0);
        check("R10 reset cl_out", cl_out, 1);
        check("R10 reset com_num", com_num, exp_com(0, n, rev));
        md = 0; mr = 0; mf = 0; ms = 0;
        total = dv * n * 3 + dv * 5;
        for (int k = 1; k <= total; k++) begin
            @(posedge clk);
            if (md == dv - 1) begin
                md = 0;
                if (mr == n - 1) begin
                    mr = 0; mf ^= 1; ms = int'(start_line);
                end else begin
                    mr++;
                end
            end else begin
                md++;
            end
            @(negedge clk);
            check("R1 R2 line_idx", line_idx, mr);
            check("R2 cl_out", cl_out, (md < dv / 2) ? 1 : 0);
            check("R3 fr_out", fr_out, mf);
            check("R4 R5 ram_line", ram_line, (ms + mr) % 65);
            check(rev ? "R7 com_num" : "R6 com_num", com_num, exp_com(mr, n, rev));
            ext_cl = 1'((k >> 2) & 1);  // R8: must be ignored here
            if (k == dv * n + 3 * dv) start_line = 6'(s1);  // R5: mid-frame write
        end
    endtask

    task automatic pulse_ext();
        ext_cl = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 cl_out follows ext_cl", cl_out, 1);
        @(negedge clk);
        ext_cl = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_all();
        for (int d = 0; d < 4; d++) begin
            for (int rv = 0; rv < 2; rv++) begin
                run_master(d, 0, 63, 1'(rv));
                run_master(d, 17, 40, 1'(rv));
            end
        end

        // Slave mode, 33 rows.
        master = 1'b0; osc_en = 1'b1; duty_sel = 2'b00; com_rev = 1'b0;
        start_line = 6'd5; ext_cl = 1'b0; ext_fr = 1'b0; ext_doff = 1'b0; disp_off = 1'b0;
        do_reset();
        check("R10 slave reset line_idx", line_idx, 0);
        check("R8 slave reset cl_out", cl_out, 0);
        ext_fr = 1'b1; ext_doff = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 slave fr_out", fr_out, 1);
        check("R9 slave doff_out", doff_out, 1);
        for (int p = 1; p <= 35; p++) begin
            pulse_ext();
            check("R8 slave line_idx", line_idx, p % 33);
            check("R4 slave ram_line", ram_line, (p < 33) ? p : (5 + p - 33) % 65);
        end
        check("R9 slave fr_out after wrap", fr_out, 1);
        ext_fr = 1'b0; ext_doff = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 slave fr_out low", fr_out, 0);
        check("R9 slave doff_out low", doff_out, 0);

        // Master with the external line clock, 49 rows, reversed.
        master = 1'b1; osc_en = 1'b0; duty_sel = 2'b01; com_rev = 1'b1;
        start_line = 6'd0; disp_off = 1'b1; ext_doff = 1'b0;
        do_reset();
        check("R9 master doff_out", doff_out, 1);
        repeat (30) @(negedge clk);
        check("R8 no edge no advance", line_idx, 0);
        for (int p = 1; p <= 48; p++) pulse_ext();
        check("R8 ext master line_idx", line_idx, 48);
        check("R7 last row indicator", com_num, 64);
        check("R3 fr before wrap", fr_out, 0);
        pulse_ext();
        check("R1 wrap 49", line_idx, 0);
        check("R3 fr after wrap", fr_out, 1);
        check("R7 top reversed", com_num, 63);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule